// File: doc/BRIEF.md
# Window Near-Median Rank Selector

This block receives one 3x3 window of pixels per transfer and returns the three values that sit just below, at, and just above the median of the window. It does not sort by swapping. Every window position has its own rank unit. That unit compares its pixel with the other eight in parallel and counts how many of them it beats. The count is the pixel's rank, from 0 for the smallest to 8 for the largest. Equal pixels are ordered by position: the pixel at the lower index counts as the smaller one. Because of this rule, the nine ranks always form a permutation of 0..8. Each output is then picked by finding the single position whose rank matches the wanted value.

Both ends of the block are valid/ready streams. A window is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on a rising edge where `out_valid` and `out_ready` are both high. The pipeline has two register stages and moves as a single unit. When `out_valid` is high and `out_ready` is low, nothing advances: the outputs hold and `in_ready` goes low. While the sink accepts every result, the block takes a new window on every cycle. A held result stays on the outputs until it is consumed.

Top module: `window_rank_sorter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Whenever `out_valid` is 1, `out_lo` <= `out_mid` <= `out_hi`.
- R3: The outputs `out_lo`, `out_mid` and `out_hi` are the 4th, 5th and 6th smallest of the nine input pixels. Pixel i is taken from bits [8*i+7 : 8*i] of `in_pix`.
- R4: Windows with repeated values give the same three outputs as a full ascending sort. Exactly one position matches each selected rank.
- R5: A window accepted on one rising edge appears on the outputs, with `out_valid` high, right after the next rising edge, provided `out_ready` is high.
- R6: While `out_valid` is 1 and `out_ready` is 0, the three outputs and `out_valid` stay stable and `in_ready` is 0.
- R7: When no window is accepted, no result appears: `out_valid` rises only for data that came through the first stage.
- R8: With `out_ready` held high, windows presented on consecutive cycles come out on consecutive cycles, in the order they went in.
- R9: Extreme pixel values (all 0, all 255, and a mix of 0 and 255) are ranked correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A window is presented on `in_pix` |
| in_ready | output | 1 | The block can take a window this cycle |
| in_pix | input | 72 | Nine 8-bit pixels; pixel i at bits [8*i+7 : 8*i] |
| out_valid | output | 1 | A result is presented on the outputs |
| out_ready | input | 1 | The sink takes the result this cycle |
| out_lo | output | 8 | 4th smallest pixel of the window |
| out_mid | output | 8 | 5th smallest pixel (the median) |
| out_hi | output | 8 | 6th smallest pixel |

## Verification
The assertions check three things on every cycle: the outputs are in ascending order, the rank vectors hold exactly one match per selected rank (so the tie-break yields a permutation), and a stalled result stays stable while input is blocked. The assertions cannot show that the selected values really are the 4th to 6th of the window, that a result appears with the stated latency, or that order is kept under back-to-back traffic. The bench's scenarios show these by comparing the outputs with a sort computed in the bench, across ascending, descending, duplicate-heavy, extreme-value, stalled and bubbled patterns.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  // bits needed to hold a rank in the range 0..n-1
  function automatic int rank_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wrs_rank_cmp.sv
module wrs_rank_cmp #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9,
  parameter int IDX   = 0
) (
  input  logic [WIN*PIX_W-1:0] pix,
  output logic [WIN-1:0]       beats
);
  logic [PIX_W-1:0] own;
  assign own = pix[IDX*PIX_W +: PIX_W];

  // an equal pixel at a lower index counts as smaller
  for (genvar k = 0; k < WIN; k++) begin : g_cmp
    if (k < IDX) begin : g_lower
      assign beats[k] = (own >= pix[k*PIX_W +: PIX_W]);
    end else if (k == IDX) begin : g_self
      assign beats[k] = 1'b0;
    end else begin : g_upper
      assign beats[k] = (own > pix[k*PIX_W +: PIX_W]);
    end
  end
endmodule

// File: rtl/wrs_rank_count.sv
module wrs_rank_count #(
  parameter int WIN = 9,
  parameter int RW  = 4
) (
  input  logic [WIN-1:0] beats,
  output logic [RW-1:0]  rank
);
  always_comb begin
    rank = '0;
    for (int k = 0; k < WIN; k++) begin
      rank = rank + RW'(beats[k]);
    end
  end
endmodule

// File: rtl/wrs_rank_select.sv
module wrs_rank_select #(
  parameter int PIX_W  = 8,
  parameter int WIN    = 9,
  parameter int RW     = 4,
  parameter int TARGET = 4
) (
  input  logic [WIN*RW-1:0]    ranks,
  input  logic [WIN*PIX_W-1:0] pix,
  output logic [WIN-1:0]       hit,
  output logic [PIX_W-1:0]     value
);
  for (genvar i = 0; i < WIN; i++) begin : g_hit
    assign hit[i] = (ranks[i*RW +: RW] == RW'(TARGET));
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < WIN; i++) begin
      value = value | (pix[i*PIX_W +: PIX_W] & {PIX_W{hit[i]}});
    end
  end
endmodule

// File: rtl/window_rank_sorter.sv
module window_rank_sorter #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WIN*PIX_W-1:0] in_pix,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PIX_W-1:0]     out_lo,
  output logic [PIX_W-1:0]     out_mid,
  output logic [PIX_W-1:0]     out_hi
);
  localparam int RW  = wrs_pkg::rank_bits(WIN);
  localparam int MID = (WIN - 1) / 2;

  logic                 advance;
  logic [WIN*WIN-1:0]   beats_c;
  logic                 s1_v;
  logic [WIN*WIN-1:0]   s1_beats;
  logic [WIN*PIX_W-1:0] s1_pix;
  logic [WIN*RW-1:0]    ranks_c;
  logic [3*WIN-1:0]     hit_all;
  logic [3*PIX_W-1:0]   sel_all;
  logic [WIN-1:0]       match_lo, match_mid, match_hi;

  // whole pipeline moves together; it stops only while a result is held
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  for (genvar i = 0; i < WIN; i++) begin : g_rank
    wrs_rank_cmp #(.PIX_W(PIX_W), .WIN(WIN), .IDX(i)) u_cmp (
      .pix   (in_pix),
      .beats (beats_c[i*WIN +: WIN])
    );
    wrs_rank_count #(.WIN(WIN), .RW(RW)) u_cnt (
      .beats (s1_beats[i*WIN +: WIN]),
      .rank  (ranks_c[i*RW +: RW])
    );
  end

  for (genvar j = 0; j < 3; j++) begin : g_sel
    wrs_rank_select #(.PIX_W(PIX_W), .WIN(WIN), .RW(RW), .TARGET(MID - 1 + j)) u_sel (
      .ranks (ranks_c),
      .pix   (s1_pix),
      .hit   (hit_all[j*WIN +: WIN]),
      .value (sel_all[j*PIX_W +: PIX_W])
    );
  end

  assign match_lo  = hit_all[0 +: WIN];
  assign match_mid = hit_all[WIN +: WIN];
  assign match_hi  = hit_all[2*WIN +: WIN];

  // stage 1: comparison bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_beats <= '0;
      s1_pix   <= '0;
    end else if (advance) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_beats <= beats_c;
        s1_pix   <= in_pix;
      end
    end
  end

  // stage 2: counted ranks and selected values
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_mid   <= '0;
      out_hi    <= '0;
    end else if (advance) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_lo  <= sel_all[0 +: PIX_W];
        out_mid <= sel_all[PIX_W +: PIX_W];
        out_hi  <= sel_all[2*PIX_W +: PIX_W];
      end
    end
  end
endmodule

// File: rtl/window_rank_sorter_chk.sv
module window_rank_sorter_chk #(
  parameter int PIX_W = 8,
  parameter int WIN   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_lo,
  input logic [PIX_W-1:0] out_mid,
  input logic [PIX_W-1:0] out_hi,
  input logic             s1_v,
  input logic [WIN-1:0]   match_lo,
  input logic [WIN-1:0]   match_mid,
  input logic [WIN-1:0]   match_hi
);
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lo <= out_mid) && (out_mid <= out_hi));

  p_unique_rank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> ($countones(match_lo) == 1) && ($countones(match_mid) == 1)
             && ($countones(match_hi) == 1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_lo)
                                  && $stable(out_mid) && $stable(out_hi));

  p_block_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_v));
endmodule

bind window_rank_sorter window_rank_sorter_chk #(.PIX_W(PIX_W), .WIN(WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_lo    (out_lo),
  .out_mid   (out_mid),
  .out_hi    (out_hi),
  .s1_v      (s1_v),
  .match_lo  (match_lo),
  .match_mid (match_mid),
  .match_hi  (match_hi)
);

// File: tb/window_rank_sorter_tb.sv
module window_rank_sorter_tb;
  typedef logic [7:0] win_t [9];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [71:0] in_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_lo, out_mid, out_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  window_rank_sorter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_lo(out_lo), .out_mid(out_mid), .out_hi(out_hi)
  );

  function automatic logic [71:0] pack(input win_t w);
    logic [71:0] v;
    for (int i = 0; i < 9; i++) v[i*8 +: 8] = w[i];
    return v;
  endfunction

  function automatic logic [7:0] ref_rank(input win_t w, input int r);
    win_t s;
    logic [7:0] t;
    s = w;
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 8 - a; b++)
        if (s[b] > s[b+1]) begin t = s[b]; s[b] = s[b+1]; s[b+1] = t; end
    return s[r];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input win_t w);
    check({req, " valid"}, out_valid, 1);
    check({req, " lo"},  out_lo,  ref_rank(w, 3));
    check({req, " mid"}, out_mid, ref_rank(w, 4));
    check({req, " hi"},  out_hi,  ref_rank(w, 5));
  endtask

  // accept on one edge, result visible after the next (R5)
  task automatic run_one(input string req, input win_t w);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_pix = pack(w);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R5 early"}, out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check_result(req, w);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_patterns();
    win_t w;
    logic [7:0] lf;
    for (int i = 0; i < 9; i++) w[i] = 8'(10 * i + 5);
    run_one("R3 ascending", w);
    for (int i = 0; i < 9; i++) w[i] = 8'(200 - 17 * i);
    run_one("R3 descending", w);
    lf = 8'h5a;
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 9; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        w[i] = lf;
      end
      run_one("R3 scrambled", w);
    end
  endtask

  task automatic t_dups();
    win_t w;
    w = '{8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7};
    run_one("R4 all equal", w);
    w = '{8'd40, 8'd9, 8'd40, 8'd9, 8'd40, 8'd9, 8'd40, 8'd9, 8'd40};
    run_one("R4 two groups", w);
    w = '{8'd3, 8'd50, 8'd50, 8'd50, 8'd1, 8'd50, 8'd99, 8'd50, 8'd2};
    run_one("R4 median block", w);
  endtask

  task automatic t_extremes();
    win_t w;
    for (int i = 0; i < 9; i++) w[i] = 8'd0;
    run_one("R9 zeros", w);
    for (int i = 0; i < 9; i++) w[i] = 8'd255;
    run_one("R9 full", w);
    w = '{8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd0};
    run_one("R9 mix", w);
  endtask

  task automatic t_stream();
    win_t ws [5];
    for (int n = 0; n < 5; n++)
      for (int i = 0; i < 9; i++) ws[n][i] = 8'((i * 37 + n * 91 + 13) % 256);
    out_ready = 1'b1;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c >= 2) check_result("R8 stream", ws[c-2]);
      if (c < 5) begin
        in_valid = 1'b1;
        in_pix = pack(ws[c]);
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    win_t a, b, c;
    for (int i = 0; i < 9; i++) begin
      a[i] = 8'(i * 11 + 1);
      b[i] = 8'(250 - i * 23);
      c[i] = 8'((i * 71) % 256);
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_pix = pack(a);
    @(posedge clk);
    @(negedge clk);
    in_pix = pack(b);
    @(posedge clk);
    @(negedge clk);
    check("R6 in_ready low", in_ready, 0);
    in_pix = pack(c);
    @(posedge clk);
    @(negedge clk);
    check_result("R6 held", a);
    check("R6 still blocked", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R6 next", b);
    @(posedge clk);
    @(negedge clk);
    check_result("R6 last", c);
    @(posedge clk);
    @(negedge clk);
    check("R6 drained", out_valid, 0);
  endtask

  task automatic t_bubble();
    @(negedge clk);
    in_valid = 1'b0;
    in_pix = '1;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      check("R7 no output", out_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_dups();
    t_extremes();
    t_stream();
    t_backpressure();
    t_bubble();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule